// File: doc/BRIEF.md
# Interrupt Message Dispatcher with Level Coalescing

This block sits between a set of interrupt input wires and an interrupt fabric that accepts memory-write style messages. For each pin it keeps a request bit. It decides which pins are eligible, picks one pin fairly and turns that pin's table entry into a 32-bit address and 32-bit data pair. The pair is sent on a valid/ready port. The routing table (mask, trigger kind, vector, delivery kind, destination, destination mode, remote-IRR) lives in an external register file and arrives here as flattened per-pin fields.

Level-triggered pins are coalesced. Sending a level message raises that pin's remote-IRR flag, and no further message goes out for that pin until an end-of-interrupt (EOI) with the matching vector clears the flag. The block never stores remote-IRR. It reports every change as a one-cycle set or clear strobe to the register file. Edge-triggered pins fire once per rising input, and a rise on a masked edge pin is lost.

Top module: `irq_dispatch`

## Requirements
- R1: A level pin (cfg_level=1) whose sampled input is high, unmasked and with remote-IRR clear produces exactly one message and a one-cycle rirr_set strobe on that pin. Once the input is low, the request is gone.
- R2: While a level pin's cfg_rirr is 1, no message is sent for it, even with its input held high.
- R3: An EOI (eoi_valid high for one cycle) pulses rirr_clr for every pin with cfg_rirr=1 whose vector equals eoi_vector. A non-matching vector produces no clear.
- R4: After a matching EOI clears remote-IRR, an unmasked level pin whose input is still high is sent again.
- R5: An unmasked edge pin (cfg_level=0) sends one message per rising input, and its request is cleared by the send. A held-high input sends nothing more, and no rirr_set is pulsed.
- R6: A rising input on a masked edge pin is discarded. Unmasking the pin afterwards sends nothing.
- R7: A masked pin is never sent. A masked level pin with a high input is sent once it is unmasked.
- R8: msg_addr = 0xFEE00000 | (destination << 4) | (destination mode << 2). The destination is 16 bits.
- R9: msg_data holds the vector in bits 7:0, the delivery kind in bits 10:8 and the trigger kind in bit 15 (1 = level). All other bits are 0.
- R10: Only one message is outstanding at a time. While msg_valid is high and msg_ready is low, msg_addr and msg_data hold steady.
- R11: Eligible pins are served in ascending order starting from a pointer that sits one past the last pin sent and wraps from the highest pin to pin 0. The pointer is 0 after reset.
- R12: After reset, msg_valid, rirr_set and rirr_clr are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | NUM_PINS | Interrupt input lines |
| cfg_mask | input | NUM_PINS | Per-pin mask |
| cfg_level | input | NUM_PINS | Per-pin trigger kind, 1 = level |
| cfg_vector | input | NUM_PINS*VEC_W | Per-pin vector |
| cfg_dmode | input | NUM_PINS*3 | Per-pin delivery kind |
| cfg_dest | input | NUM_PINS*DEST_W | Per-pin destination |
| cfg_dstmode | input | NUM_PINS | Per-pin destination mode |
| cfg_rirr | input | NUM_PINS | Remote-IRR flags held in the register file |
| rirr_set | output | NUM_PINS | One-cycle set strobe for remote-IRR |
| rirr_clr | output | NUM_PINS | One-cycle clear strobe for remote-IRR |
| eoi_valid | input | 1 | EOI broadcast strobe |
| eoi_vector | input | VEC_W | Vector carried by the EOI |
| msg_valid | output | 1 | Outgoing message valid |
| msg_ready | input | 1 | Receiver accepts the message |
| msg_addr | output | 32 | Message address word |
| msg_data | output | 32 | Message data word |

## Verification
The bench builds the block with its defaults: 24 pins, 8-bit vectors and 16-bit destinations. With 24 pins, the picker's pointer can be driven past the top pin, so the wrap from pin 23 to pin 2 is checked. The full-width destination puts bits into both address nibbles next to the fixed base. The bench models the register file itself and applies the set and clear strobes. This makes it possible to observe the full remote-IRR handshake: coalescing, a mismatched EOI, and a resend after a matching EOI.

// File: rtl/irqd_pkg.sv
package irqd_pkg;
  localparam logic [31:0] MSG_BASE      = 32'hFEE0_0000;
  localparam int          DEST_SHIFT    = 4;
  localparam int          DSTMODE_SHIFT = 2;
  localparam int          DMODE_SHIFT   = 8;
  localparam int          TRIG_SHIFT    = 15;
  localparam int          DMODE_W       = 3;
endpackage

// File: rtl/irqd_req_bank.sv
module irqd_req_bank #(
  parameter int NUM_PINS = 24
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] irq_in,
  input  logic [NUM_PINS-1:0] cfg_mask,
  input  logic [NUM_PINS-1:0] cfg_level,
  input  logic [NUM_PINS-1:0] sent,
  output logic [NUM_PINS-1:0] req
);
  logic [NUM_PINS-1:0] in_q;
  logic [NUM_PINS-1:0] rise;

  assign rise = irq_in & ~in_q;

  always_ff @(posedge clk) begin
    if (rst) in_q <= '0;
    else     in_q <= irq_in;
  end

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    always_ff @(posedge clk) begin
      if (rst)               req[i] <= 1'b0;
      else if (cfg_level[i]) req[i] <= irq_in[i];
      else                   req[i] <= (req[i] & ~sent[i]) | (rise[i] & ~cfg_mask[i]);
    end

    // R5: an edge request that was sent and not re-armed must drop
    assert_edge_consumed_R5: assert property (@(posedge clk) disable iff (rst)
      (!cfg_level[i] && sent[i] && !rise[i]) |=> !req[i]);
  end
endmodule

// File: rtl/irqd_rr_pick.sv
module irqd_rr_pick #(
  parameter int NUM_PINS = 24,
  localparam int IDX_W = $clog2(NUM_PINS)
) (
  input  logic [NUM_PINS-1:0] elig,
  input  logic [IDX_W-1:0]    ptr,
  output logic [NUM_PINS-1:0] gnt,
  output logic [IDX_W-1:0]    gnt_idx,
  output logic                any
);
  always_comb begin
    gnt     = '0;
    gnt_idx = '0;
    any     = 1'b0;
    for (int k = 0; k < NUM_PINS; k++) begin
      int p;
      p = int'(ptr) + k;
      if (p >= NUM_PINS) p = p - NUM_PINS;
      if (!any && elig[p]) begin
        any     = 1'b1;
        gnt[p]  = 1'b1;
        gnt_idx = IDX_W'(p);
      end
    end
  end

  always_comb begin
    assert_gnt_onehot_R11: assert ($onehot0(gnt));
    assert_gnt_elig_R11:   assert ((gnt & ~elig) == '0);
  end
endmodule

// File: rtl/irqd_msg_fmt.sv
module irqd_msg_fmt
  import irqd_pkg::*;
#(
  parameter int VEC_W  = 8,
  parameter int DEST_W = 16
) (
  input  logic [VEC_W-1:0]   vec,
  input  logic [DMODE_W-1:0] dmode,
  input  logic               level,
  input  logic [DEST_W-1:0]  dest,
  input  logic               dstmode,
  output logic [31:0]        addr,
  output logic [31:0]        data
);
  assign addr = MSG_BASE | (32'(dest) << DEST_SHIFT) | (32'(dstmode) << DSTMODE_SHIFT);
  assign data = 32'(vec) | (32'(dmode) << DMODE_SHIFT) | (32'(level) << TRIG_SHIFT);
endmodule

// File: rtl/irq_dispatch.sv
module irq_dispatch
  import irqd_pkg::*;
#(
  parameter int NUM_PINS = 24,
  parameter int VEC_W    = 8,
  parameter int DEST_W   = 16
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [NUM_PINS-1:0]          irq_in,
  input  logic [NUM_PINS-1:0]          cfg_mask,
  input  logic [NUM_PINS-1:0]          cfg_level,
  input  logic [NUM_PINS*VEC_W-1:0]    cfg_vector,
  input  logic [NUM_PINS*DMODE_W-1:0]  cfg_dmode,
  input  logic [NUM_PINS*DEST_W-1:0]   cfg_dest,
  input  logic [NUM_PINS-1:0]          cfg_dstmode,
  input  logic [NUM_PINS-1:0]          cfg_rirr,
  output logic [NUM_PINS-1:0]          rirr_set,
  output logic [NUM_PINS-1:0]          rirr_clr,
  input  logic                         eoi_valid,
  input  logic [VEC_W-1:0]             eoi_vector,
  output logic                         msg_valid,
  input  logic                         msg_ready,
  output logic [31:0]                  msg_addr,
  output logic [31:0]                  msg_data
);
  localparam int IDX_W = $clog2(NUM_PINS);

  logic [NUM_PINS-1:0] req, elig, gnt, sent;
  logic [IDX_W-1:0]    ptr, gnt_idx;
  logic                any, launch;
  logic [31:0]         f_addr, f_data;

  assign elig   = req & ~cfg_mask & (~cfg_level | ~cfg_rirr);
  assign launch = any & ~msg_valid;
  assign sent   = launch ? gnt : '0;

  irqd_req_bank #(.NUM_PINS(NUM_PINS)) u_req (
    .clk(clk), .rst(rst), .irq_in(irq_in), .cfg_mask(cfg_mask),
    .cfg_level(cfg_level), .sent(sent), .req(req)
  );

  irqd_rr_pick #(.NUM_PINS(NUM_PINS)) u_pick (
    .elig(elig), .ptr(ptr), .gnt(gnt), .gnt_idx(gnt_idx), .any(any)
  );

  irqd_msg_fmt #(.VEC_W(VEC_W), .DEST_W(DEST_W)) u_fmt (
    .vec    (cfg_vector[gnt_idx*VEC_W +: VEC_W]),
    .dmode  (cfg_dmode[gnt_idx*DMODE_W +: DMODE_W]),
    .level  (cfg_level[gnt_idx]),
    .dest   (cfg_dest[gnt_idx*DEST_W +: DEST_W]),
    .dstmode(cfg_dstmode[gnt_idx]),
    .addr   (f_addr),
    .data   (f_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      msg_valid <= 1'b0;
      msg_addr  <= '0;
      msg_data  <= '0;
      ptr       <= '0;
      rirr_set  <= '0;
    end else begin
      rirr_set <= '0;
      if (launch) begin
        msg_valid <= 1'b1;
        msg_addr  <= f_addr;
        msg_data  <= f_data;
        ptr       <= (gnt_idx == IDX_W'(NUM_PINS-1)) ? '0 : gnt_idx + 1'b1;
        rirr_set  <= gnt & cfg_level;
      end else if (msg_valid && msg_ready) begin
        msg_valid <= 1'b0;
      end
    end
  end

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_eoi
    always_ff @(posedge clk) begin
      if (rst) rirr_clr[i] <= 1'b0;
      else     rirr_clr[i] <= eoi_valid & cfg_rirr[i] &
                              (cfg_vector[i*VEC_W +: VEC_W] == eoi_vector);
    end
  end

  assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_addr) && $stable(msg_data)));
  assert_single_set_R1: assert property (@(posedge clk) disable iff (rst)
    $onehot0(rirr_set));
  assert_set_with_msg_R1: assert property (@(posedge clk) disable iff (rst)
    (|rirr_set) |-> msg_valid);
  assert_clr_after_eoi_R3: assert property (@(posedge clk) disable iff (rst)
    (|rirr_clr) |-> $past(eoi_valid));
  assert_addr_base_R8: assert property (@(posedge clk) disable iff (rst)
    msg_valid |-> (msg_addr[31:20] == 12'hFEE));
endmodule

// File: tb/tb_irq_dispatch.sv
`timescale 1ns/1ps
module tb_irq_dispatch;
  localparam int N = 24;
  localparam int VW = 8;
  localparam int DW = 16;

  logic clk = 0, rst = 1;
  always #4 clk = ~clk;

  logic [N-1:0]      irq_in = '0, mask_r = '0, level_r = '0, dstmode_r, rirr_q;
  logic [N*VW-1:0]   vec_r;
  logic [N*3-1:0]    dmode_r;
  logic [N*DW-1:0]   dest_r;
  logic [N-1:0]      rirr_set, rirr_clr;
  logic              eoi_valid = 0, msg_ready = 1, msg_valid;
  logic [VW-1:0]     eoi_vector = '0;
  logic [31:0]       msg_addr, msg_data;

  irq_dispatch dut (
    .clk(clk), .rst(rst), .irq_in(irq_in), .cfg_mask(mask_r), .cfg_level(level_r),
    .cfg_vector(vec_r), .cfg_dmode(dmode_r), .cfg_dest(dest_r), .cfg_dstmode(dstmode_r),
    .cfg_rirr(rirr_q), .rirr_set(rirr_set), .rirr_clr(rirr_clr),
    .eoi_valid(eoi_valid), .eoi_vector(eoi_vector), .msg_valid(msg_valid),
    .msg_ready(msg_ready), .msg_addr(msg_addr), .msg_data(msg_data)
  );

  // register-file model for remote-IRR
  always @(posedge clk)
    if (rst) rirr_q <= '0;
    else     rirr_q <= (rirr_q | rirr_set) & ~rirr_clr;

  int nmsg = 0;
  logic [31:0] log_addr [0:63];
  logic [31:0] log_data [0:63];
  always @(posedge clk)
    if (!rst && msg_valid && msg_ready) begin
      log_addr[nmsg[5:0]] <= msg_addr;
      log_data[nmsg[5:0]] <= msg_data;
      nmsg <= nmsg + 1;
    end

  int checks = 0, fails = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] exp_addr(int p);
    return 32'hFEE0_0000 | (32'(16'h1000 + p) << 4) | (32'(p % 2) << 2);
  endfunction
  function automatic logic [31:0] exp_data(int p, logic lvl);
    return 32'(8'h40 + p) | (32'(p % 8) << 8) | (32'(lvl) << 15);
  endfunction

  task automatic eoi(logic [7:0] v);
    eoi_vector = v; eoi_valid = 1; cyc(1); eoi_valid = 0;
  endtask

  task automatic t_reset;
    chk("R12 valid", 32'(msg_valid), 0);
    chk("R12 set", 32'(rirr_set), 0);
    chk("R12 clr", 32'(rirr_clr), 0);
  endtask

  task automatic t_level;
    int base;
    base = nmsg;
    level_r[4] = 1; irq_in[4] = 1; cyc(6);
    chk("R1 count", nmsg - base, 1);
    chk("R8 addr", log_addr[base], exp_addr(4));
    chk("R9 data", log_data[base], exp_data(4, 1));
    chk("R1 rirr", 32'(rirr_q[4]), 1);
    cyc(10);
    chk("R2 coalesce", nmsg - base, 1);
    eoi(8'h99); cyc(4);
    chk("R3 mismatch rirr", 32'(rirr_q[4]), 1);
    eoi(8'h44); cyc(6);
    chk("R4 resend", nmsg - base, 2);
    chk("R4 rirr again", 32'(rirr_q[4]), 1);
    irq_in[4] = 0; cyc(2);
    eoi(8'h44); cyc(6);
    chk("R3 cleared", 32'(rirr_q[4]), 0);
    chk("R1 low no send", nmsg - base, 2);
    level_r[4] = 0;
  endtask

  task automatic t_edge;
    int base;
    base = nmsg;
    irq_in[9] = 1; cyc(6);
    chk("R5 one", nmsg - base, 1);
    chk("R9 edge data", log_data[base], exp_data(9, 0));
    chk("R8 edge addr", log_addr[base], exp_addr(9));
    cyc(10);
    chk("R5 held", nmsg - base, 1);
    chk("R5 no rirr", 32'(rirr_q[9]), 0);
    irq_in[9] = 0; cyc(2);
  endtask

  task automatic t_mask_edge;
    int base;
    base = nmsg;
    mask_r[10] = 1; irq_in[10] = 1; cyc(4);
    mask_r[10] = 0; cyc(6);
    chk("R6 dropped", nmsg - base, 0);
    irq_in[10] = 0; cyc(2);
  endtask

  task automatic t_mask_level;
    int base;
    base = nmsg;
    level_r[11] = 1; mask_r[11] = 1; irq_in[11] = 1; cyc(6);
    chk("R7 masked", nmsg - base, 0);
    mask_r[11] = 0; cyc(6);
    chk("R7 unmasked", nmsg - base, 1);
    chk("R7 vec", log_data[base], exp_data(11, 1));
    irq_in[11] = 0; cyc(2); eoi(8'h4B); cyc(4);
    level_r[11] = 0;
  endtask

  task automatic t_rr;
    int base;
    base = nmsg;
    irq_in[3] = 1; irq_in[5] = 1; cyc(10);
    chk("R11 count", nmsg - base, 2);
    chk("R11 first", log_data[base], exp_data(3, 0));
    chk("R11 second", log_data[base+1], exp_data(5, 0));
    irq_in[3] = 0; irq_in[5] = 0; cyc(2);
    irq_in[2] = 1; irq_in[23] = 1; cyc(10);
    chk("R11 wrap first", log_data[base+2], exp_data(23, 0));
    chk("R11 wrap second", log_data[base+3], exp_data(2, 0));
    irq_in[2] = 0; irq_in[23] = 0; cyc(2);
  endtask

  task automatic t_ready;
    int base;
    base = nmsg;
    msg_ready = 0;
    irq_in[7] = 1; cyc(2); irq_in[8] = 1; cyc(8);
    chk("R10 valid held", 32'(msg_valid), 1);
    chk("R10 data held", msg_data, exp_data(7, 0));
    chk("R10 addr held", msg_addr, exp_addr(7));
    chk("R10 none taken", nmsg - base, 0);
    msg_ready = 1; cyc(8);
    chk("R10 drained", nmsg - base, 2);
    chk("R10 order", log_data[base+1], exp_data(8, 0));
    irq_in[7] = 0; irq_in[8] = 0; cyc(2);
  endtask

  task automatic finish_up;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin
      vec_r[i*VW +: VW]  = 8'(8'h40 + i);
      dmode_r[i*3 +: 3]  = 3'(i % 8);
      dest_r[i*DW +: DW] = 16'(16'h1000 + i);
      dstmode_r[i]       = 1'(i % 2);
    end
    cyc(3); rst = 0; cyc(1);
    t_reset;
    t_level;
    t_edge;
    t_mask_edge;
    t_mask_level;
    t_rr;
    t_ready;
    finish_up;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up;
  end
endmodule